// File: doc/BRIEF.md
# Locked Bus Cycle and Hold Arbiter

This block sits in the bus interface of a 32-bit processor. It drives the active-low bus-lock and pseudo-lock outputs and decides when an external bus-hold request may be acknowledged. The core marks each bus cycle with a one-clock start strobe and gives, in that same clock, the cycle's attributes: read or write, locked or not, and whether it is the start of an 8-byte descriptor transfer. The external system returns the cache-enable and bus-size inputs, and the block counts how many bus cycles the transaction needs. The system ends each cycle with the non-burst or the burst ready strobe.

Lock requests, hold requests, address-hold requests and back-off all meet in this block. A locked sequence keeps the bus from being handed away, but address-hold and back-off are still honoured. The output-enable flags show when the control pins and the address pins must float. A locked read that would otherwise become a cache line fill raises a stop flag and stays a single-cycle transfer. In write-back mode the pseudo-lock output is held inactive.

Top module: `bus_lock_arbiter`

## Requirements
- R1: `lockN` goes low combinationally in the clock in which a cycle is accepted with `lockReq` high. It stays low for the rest of the locked sequence. A cycle is accepted when `cycStart` is high, no cycle is in flight, `hlda` is low and `boffN` is high.
- R2: `lockN` returns high in the clock after a locked cycle ends while `lockReq` is low. It also returns high in the clock after any idle clock in which `lockReq` is low.
- R3: A locked cycle ends only on `rdyN` low, and `brdyN` is ignored for it. An unlocked cycle ends on either ready strobe. No ready strobe counts in a cycle's start clock or while `boffN` is low.
- R4: `hlda` rises in the clock after a clock with `holdReq` high, no cycle in flight, `cycStart` low and the lock inactive. It then stays high until the clock after `holdReq` goes low.
- R5: `hlda` is never high while `lockN` is low. A hold request made during a locked sequence is only acknowledged after the lock has been released.
- R6: `addrOe` is low in every clock with `aholdReq` high, including clocks inside a locked sequence. `ctlOe` and `addrOe` are both low while `boffN` is low, and during that time no cycle is accepted or ended.
- R7: `ctlOe`, which enables the `lockN` and `plockN` drivers, is low in every clock in which `hlda` is high.
- R8: A locked read accepted with `kenN` low raises `fillStop` from its start clock through its ending clock. It is treated as a single 4-byte transfer and not as a line fill.
- R9: At the first cycle of a transaction the block picks the byte count and the port width, both sampled at that first start. The byte count is 16 for an unlocked read with `kenN` low, 8 for `multiReq` high, and 4 otherwise. The port width is 1 byte for `bs8N` low, 2 bytes for `bs16N` low (when `bs8N` is high), and 4 bytes otherwise. The transaction takes byte count divided by width cycles. When that is more than one, `plockN` is low from the first start clock through the start clock of the last cycle, and high after it.
- R10: While `wbMode` is high, `plockN` is high in every clock.
- R11: While `rstN` is low and the inputs are idle, the outputs are `lockN`=1, `plockN`=1, `hlda`=0, `ctlOe`=1, `addrOe`=1 and `fillStop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycStart | input | 1 | Core starts a bus cycle this clock |
| cycRead | input | 1 | The starting cycle is a read |
| lockReq | input | 1 | Core requests locked cycles; dropping it marks the last one |
| multiReq | input | 1 | The starting transfer is an 8-byte descriptor access |
| rdyN | input | 1 | Non-burst ready, active low |
| brdyN | input | 1 | Burst ready, active low |
| holdReq | input | 1 | External bus-hold request |
| aholdReq | input | 1 | External address-hold request |
| boffN | input | 1 | Back-off, active low |
| bs8N | input | 1 | 8-bit port, active low |
| bs16N | input | 1 | 16-bit port, active low |
| kenN | input | 1 | Cache enable, active low |
| wbMode | input | 1 | Write-back mode |
| lockN | output | 1 | Bus lock, active low |
| plockN | output | 1 | Pseudo-lock, active low |
| hlda | output | 1 | Hold acknowledge |
| ctlOe | output | 1 | Drive enable for the lock and pseudo-lock pins |
| addrOe | output | 1 | Drive enable for the address pins |
| fillStop | output | 1 | Stop line fill for the current locked read |

## Verification
The hardest case to reach is a hold request that arrives in the middle of a locked sequence, with a burst ready strobe that must be ignored and an address-hold request arriving at the same time. That hold request must stay unanswered until the lock drops and the bus is idle. The bench holds `holdReq` high across two locked cycles, pulses `brdyN` inside the first and `aholdReq` inside the second, and drops `lockReq` only at the final ready strobe. A back-off pulse that overlaps a ready strobe, and pseudo-locked transactions on 8- and 16-bit ports, fill in the rest. A behavioural model is compared against the design on every clock.

// File: rtl/bla_pkg.sv
package bla_pkg;

  // Strobes from the control half to the transaction datapath.
  typedef struct packed {
    logic startOk;      // a bus cycle is accepted this clock
    logic endOk;        // the cycle in flight terminates this clock
    logic lockedStart;  // the accepted cycle belongs to a locked sequence
  } ctlStrobe_t;

endpackage

// File: rtl/bla_lock_ctl.sv
module bla_lock_ctl
  import bla_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycStart,
  input  logic       lockReq,
  input  logic       rdyN,
  input  logic       brdyN,
  input  logic       holdReq,
  input  logic       aholdReq,
  input  logic       boffN,
  output ctlStrobe_t strb,
  output logic       lockN,
  output logic       hlda,
  output logic       ctlOe,
  output logic       addrOe
);

  logic busyQ;
  logic curLockedQ;
  logic lockQ;
  logic hldaQ;
  logic startOk;
  logic endOk;
  logic lockedStart;
  logic releaseLock;
  logic hldaNext;

  always_comb begin
    startOk     = cycStart & ~busyQ & ~hldaQ & boffN;
    // locked cycles ignore the burst ready strobe
    endOk       = busyQ & boffN & (~rdyN | (~brdyN & ~curLockedQ));
    lockedStart = startOk & lockReq;
    releaseLock = ~lockReq & ((endOk & curLockedQ) | ~busyQ);
    hldaNext    = holdReq & (hldaQ | (~busyQ & ~cycStart & ~lockQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      curLockedQ <= 1'b0;
      lockQ      <= 1'b0;
      hldaQ      <= 1'b0;
    end else begin
      if (startOk) begin
        busyQ      <= 1'b1;
        curLockedQ <= lockReq;
      end else if (endOk) begin
        busyQ <= 1'b0;
      end
      if (lockedStart)      lockQ <= 1'b1;
      else if (releaseLock) lockQ <= 1'b0;
      hldaQ <= hldaNext;
    end
  end

  always_comb begin
    strb.startOk     = startOk;
    strb.endOk       = endOk;
    strb.lockedStart = lockedStart;
    lockN            = ~(lockQ | lockedStart);
    hlda             = hldaQ;
    ctlOe            = ~hldaQ & boffN;
    addrOe           = ~hldaQ & boffN & ~aholdReq;
  end

endmodule

// File: rtl/bla_txn_dp.sv
module bla_txn_dp
  import bla_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int DESC_BYTES = 8,
  parameter int LINE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic       cycRead,
  input  logic       kenN,
  input  logic       multiReq,
  input  logic       bs8N,
  input  logic       bs16N,
  input  logic       wbMode,
  output logic       plockN,
  output logic       fillStop
);

  localparam int CNT_W = $clog2(LINE_BYTES + 1);

  logic [CNT_W-1:0] leftQ;
  logic [CNT_W-1:0] totalCycles;
  logic [CNT_W-1:0] leftAfter;
  logic             firstCyc;
  logic             fillPick;
  logic             fillHit;
  logic             fillQ;
  logic             plockHit;
  int unsigned      xferBytes;
  int unsigned      laneBytes;

  always_comb begin
    fillPick  = cycRead & ~kenN & ~strb.lockedStart;
    fillHit   = strb.lockedStart & cycRead & ~kenN;
    xferBytes = fillPick ? LINE_BYTES : (multiReq ? DESC_BYTES : DATA_BYTES);
    laneBytes = !bs8N ? 1 : (!bs16N ? 2 : DATA_BYTES);
    totalCycles = CNT_W'(xferBytes / laneBytes);
    firstCyc  = (leftQ == '0);
    leftAfter = firstCyc ? (totalCycles - CNT_W'(1)) : (leftQ - CNT_W'(1));
    if (strb.startOk) plockHit = firstCyc ? (totalCycles > CNT_W'(1)) : 1'b1;
    else              plockHit = (leftQ != '0);
    plockN   = ~(plockHit & ~wbMode);
    fillStop = fillHit | fillQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ <= '0;
      fillQ <= 1'b0;
    end else begin
      if (strb.startOk) begin
        leftQ <= leftAfter;
        fillQ <= fillHit;
      end else if (strb.endOk) begin
        fillQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
  import bla_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int DESC_BYTES = 8,
  parameter int LINE_BYTES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycStart,
  input  logic cycRead,
  input  logic lockReq,
  input  logic multiReq,
  input  logic rdyN,
  input  logic brdyN,
  input  logic holdReq,
  input  logic aholdReq,
  input  logic boffN,
  input  logic bs8N,
  input  logic bs16N,
  input  logic kenN,
  input  logic wbMode,
  output logic lockN,
  output logic plockN,
  output logic hlda,
  output logic ctlOe,
  output logic addrOe,
  output logic fillStop
);

  ctlStrobe_t strb;

  bla_lock_ctl i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .lockReq  (lockReq),
    .rdyN     (rdyN),
    .brdyN    (brdyN),
    .holdReq  (holdReq),
    .aholdReq (aholdReq),
    .boffN    (boffN),
    .strb     (strb),
    .lockN    (lockN),
    .hlda     (hlda),
    .ctlOe    (ctlOe),
    .addrOe   (addrOe)
  );

  bla_txn_dp #(
    .DATA_BYTES (DATA_BYTES),
    .DESC_BYTES (DESC_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cycRead  (cycRead),
    .kenN     (kenN),
    .multiReq (multiReq),
    .bs8N     (bs8N),
    .bs16N    (bs16N),
    .wbMode   (wbMode),
    .plockN   (plockN),
    .fillStop (fillStop)
  );

endmodule

// File: rtl/bla_checker.sv
module bla_checker (
  input logic clk,
  input logic rstN,
  input logic holdReq,
  input logic aholdReq,
  input logic wbMode,
  input logic lockN,
  input logic plockN,
  input logic hlda,
  input logic ctlOe,
  input logic addrOe
);

  // R5
  no_hold_under_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hlda && !lockN));

  // R10
  wb_plock_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbMode |-> plockN);

  // R7
  float_in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !ctlOe);

  // R6
  ahold_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    aholdReq |-> !addrOe);

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && holdReq) |=> hlda);

  // R4
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && !holdReq) |=> !hlda);

endmodule

bind bus_lock_arbiter bla_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .holdReq  (holdReq),
  .aholdReq (aholdReq),
  .wbMode   (wbMode),
  .lockN    (lockN),
  .plockN   (plockN),
  .hlda     (hlda),
  .ctlOe    (ctlOe),
  .addrOe   (addrOe)
);

// File: tb/test_bus_lock_arbiter.sv
`timescale 1ns/1ps
module test_bus_lock_arbiter;

  logic clk = 1'b0;
  logic rstN, cycStart, cycRead, lockReq, multiReq, rdyN, brdyN;
  logic holdReq, aholdReq, boffN, bs8N, bs16N, kenN, wbMode;
  logic lockN, plockN, hlda, ctlOe, addrOe, fillStop;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  bit mBusy, mCurLocked, mLock, mHlda, mFill;
  int mLeft;

  always #4 clk = ~clk;

  bus_lock_arbiter i_bus_lock_arbiter (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycRead(cycRead),
    .lockReq(lockReq), .multiReq(multiReq), .rdyN(rdyN), .brdyN(brdyN),
    .holdReq(holdReq), .aholdReq(aholdReq), .boffN(boffN), .bs8N(bs8N),
    .bs16N(bs16N), .kenN(kenN), .wbMode(wbMode), .lockN(lockN),
    .plockN(plockN), .hlda(hlda), .ctlOe(ctlOe), .addrOe(addrOe),
    .fillStop(fillStop)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: compare at the current input set, then advance the model.
  task automatic step();
    bit startOk, endOk, first;
    int bytes, width, total;
    bit eLockN, ePlockN, eFill;
    #1;
    startOk = cycStart && !mBusy && !mHlda && boffN;
    // R3: locked cycles end on the non-burst ready only
    endOk   = mBusy && boffN && (!rdyN || (!brdyN && !mCurLocked));
    first   = (mLeft == 0);
    bytes   = (cycRead && !kenN && !lockReq) ? 16 : (multiReq ? 8 : 4);
    width   = !bs8N ? 1 : (!bs16N ? 2 : 4);
    total   = bytes / width;
    eLockN  = !(mLock || (startOk && lockReq));
    if (wbMode) ePlockN = 1;
    else if (startOk) ePlockN = first ? !(total > 1) : 0;
    else ePlockN = !(mLeft > 0);
    eFill = (startOk && lockReq && cycRead && !kenN) || mFill;
    chk("R1/R2/R3", "lockN", lockN, eLockN);
    chk("R9/R10", "plockN", plockN, ePlockN);
    chk("R4", "hlda", hlda, mHlda);
    chk("R7", "ctlOe", ctlOe, !mHlda && boffN);
    chk("R6", "addrOe", addrOe, !mHlda && boffN && !aholdReq);
    chk("R8", "fillStop", fillStop, eFill);
    chk("R5", "hold under lock", hlda && !lockN, 1'b0);
    @(posedge clk);
    mHlda = holdReq && (mHlda || (!mBusy && !cycStart && !mLock));
    if (startOk && lockReq) mLock = 1;
    else if (!lockReq && ((endOk && mCurLocked) || !mBusy)) mLock = 0;
    if (startOk) begin
      mLeft = first ? total - 1 : mLeft - 1;
      mFill = lockReq && cycRead && !kenN;
      mCurLocked = lockReq;
      mBusy = 1;
    end else if (endOk) begin
      mFill = 0;
      mBusy = 0;
    end
    @(negedge clk);
  endtask

  task automatic cyc(input bit rd, input bit kn, input bit mu, input bit lk,
                     input int waits, input bit junkBrdy, input bit dropLock);
    lockReq = lk; cycRead = rd; kenN = kn; multiReq = mu; cycStart = 1;
    step();
    cycStart = 0;
    for (int i = 0; i < waits; i++) begin
      brdyN = !(junkBrdy && i == 0);
      step();
    end
    brdyN = 1; rdyN = 0;
    if (dropLock) lockReq = 0;
    step();
    rdyN = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; cycStart = 0; cycRead = 0; lockReq = 0; multiReq = 0;
    rdyN = 1; brdyN = 1; holdReq = 0; aholdReq = 0; boffN = 1;
    bs8N = 1; bs16N = 1; kenN = 1; wbMode = 0;
    mBusy = 0; mCurLocked = 0; mLock = 0; mHlda = 0; mFill = 0; mLeft = 0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "lockN", lockN, 1); chk("R11", "plockN", plockN, 1);
    chk("R11", "hlda", hlda, 0);   chk("R11", "ctlOe", ctlOe, 1);
    chk("R11", "addrOe", addrOe, 1); chk("R11", "fillStop", fillStop, 0);
    @(negedge clk);
    rstN = 1;
    step();

    // plain write, then a 32-bit line fill (R9)
    cyc(0, 1, 0, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 0);
    step();
    // descriptor read on 16-bit port, then write on 8-bit port (R9)
    bs16N = 0;
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 1, 0, 0);
    bs16N = 1; bs8N = 0;
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, 0);
    bs8N = 1; multiReq = 0;
    step();
    // write-back mode line fill keeps pseudo-lock high (R10)
    wbMode = 1;
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 0);
    wbMode = 0;
    step();

    // locked read with cache enable, ignored burst ready, pending hold (R1 R3 R5 R8)
    holdReq = 1;
    step();
    step();
    holdReq = 0;
    step();
    step();
    holdReq = 1;
    cyc(1, 0, 0, 1, 2, 1, 0);
    step();
    aholdReq = 1;
    cyc(0, 1, 0, 1, 1, 0, 1);   // last locked cycle (R2)
    aholdReq = 0;
    repeat (3) step();
    cycStart = 1;                // ignored during hold (R4)
    step();
    cycStart = 0;
    holdReq = 0;
    repeat (2) step();

    // back-off over a ready strobe inside a cycle (R6)
    cycRead = 1; kenN = 1; cycStart = 1;
    step();
    cycStart = 0;
    boffN = 0; rdyN = 0;
    step();
    boffN = 1; rdyN = 1;
    step();
    rdyN = 0;
    step();
    rdyN = 1;
    step();

    // locked sequence with an idle gap, released while idle (R2)
    cyc(1, 1, 0, 1, 0, 0, 0);
    holdReq = 1;
    repeat (2) step();
    lockReq = 0;
    repeat (3) step();
    holdReq = 0;
    repeat (2) step();
    // unlocked cycle ends on burst ready (R3)
    cyc(1, 1, 0, 0, 1, 1, 0);
    repeat (2) step();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule